// File: doc/BRIEF.md
# NMI pad trigger latch

This block conditions a single external non-maskable interrupt pad and keeps a sticky request for a downstream interrupt controller. The pad passes through a synchronizer. A programmable sense stage then turns it into a set event. Two sense modes act on a level and two act on an edge. The set event loads a set/reset latch. The latch output goes upstream as an active-high level, whichever sense mode is selected.

Software reaches the block through three decoded strobes. A mode write loads the 2-bit sense field. A write to the pending register clears the latch when data bit 0 is 1. An enable level comes from the enable register. The pending bit that software reads is the latch output gated by that enable. Bus decoding is handled outside this block.

Top module: `nmi_trig_latch`

## Requirements
- R1: While reset is asserted and after it is released, the block shows `irq_o`=0, `pend_o`=0 and `mode_o`=0 (level-low).
- R2: A cycle with `mode_wr_i`=1 loads `mode_wdata_i[1:0]` into `mode_o` at the next clock edge. The upper data bits are ignored. Without a write, `mode_o` holds its value. The encodings are 0=level-low, 1=falling edge, 2=level-high and 3=rising edge.
- R3: In mode 2, a high level on `pad_i` sets `irq_o`. The output rises at the third rising clock edge after the pad changes: two synchronizer edges, then one latch edge.
- R4: In mode 0, a low level on `pad_i` sets `irq_o`, with the same three-edge latency.
- R5: In mode 3, only a 0-to-1 transition of the pad sets `irq_o`. A pad that stays high, or a 1-to-0 transition, does not set it.
- R6: In mode 1, only a 1-to-0 transition of the pad sets `irq_o`. A pad that stays low, or a 0-to-1 transition, does not set it.
- R7: A cycle with `clr_wr_i`=1 and `clr_data_i[0]`=1 clears `irq_o` at the next edge, unless a set event occurs. A clear write with bit 0 = 0 has no effect, whatever the other bits are.
- R8: When a set event and a clear occur in the same cycle, the set wins. In a level mode with the pad still active, a clear leaves `irq_o` at 1.
- R9: `pend_o` equals `irq_o` AND `en_i` in every cycle.
- R10: Changing the sense mode does not clear the latch. A mode change while the pad is steady does not create an edge event.
- R11: Once set, `irq_o` stays at 1 until a clear takes effect, even after the pad returns to its inactive state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pad_i | input | 1 | Asynchronous external NMI pad |
| mode_wr_i | input | 1 | Write strobe for the sense-mode field |
| mode_wdata_i | input | DATA_W | Write data; bits [1:0] hold the mode |
| clr_wr_i | input | 1 | Write strobe for the pending register |
| clr_data_i | input | DATA_W | Write data; 1 in bit 0 clears the latch |
| en_i | input | 1 | Enable bit that gates the readable pending bit |
| mode_o | output | 2 | Current sense mode |
| irq_o | output | 1 | Latched request, active-high level to the controller |
| pend_o | output | 1 | Readable pending bit (latch AND enable) |

## Verification
The assertions check on every cycle that the pending bit tracks latch AND enable, that the mode field moves only on a write and then takes the written value, and that the latch falls only one cycle after a write-one clear. They also check that a set latch holds without a clear, and that a level-high pad held for three cycles always sets it. Only the bench scenarios can show the mode-specific behaviour: the exact three-edge latency, that opposite or steady edges are ignored, the set-over-clear priority in each mode, and that a mode change alone neither sets nor clears the latch.

// File: rtl/nmi_latch_pkg.sv
package nmi_latch_pkg;
  localparam int unsigned MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    SENSE_LVL_LO = 2'd0,
    SENSE_FALL   = 2'd1,
    SENSE_LVL_HI = 2'd2,
    SENSE_RISE   = 2'd3
  } sense_e;
endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   sh_q[i] <= RST_VAL;
        else if (i == 0) sh_q[i] <= d_i;
        else             sh_q[i] <= sh_q[(i > 0) ? i-1 : 0];
      end
    end
  endgenerate

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/nmi_sense.sv
module nmi_sense
  import nmi_latch_pkg::*;
#(
  parameter logic RST_VAL = 1'b1
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   s_i,
  input  sense_e mode_i,
  output logic   evt_o
);
  logic prev_q;

  // previous sample always tracks, so a mode switch never fabricates an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= s_i;
  end

  always_comb begin
    unique case (mode_i)
      SENSE_LVL_LO: evt_o = ~s_i;
      SENSE_FALL:   evt_o = prev_q & ~s_i;
      SENSE_LVL_HI: evt_o = s_i;
      SENSE_RISE:   evt_o = s_i & ~prev_q;
      default:      evt_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/nmi_mode_reg.sv
module nmi_mode_reg
  import nmi_latch_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output sense_e            mode_o
);
  sense_e mode_q;
  logic   unused_hi;

  assign unused_hi = ^wdata_i[DATA_W-1:MODE_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mode_q <= SENSE_LVL_LO;
    else if (wr_i) mode_q <= sense_e'(wdata_i[MODE_W-1:0]);
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/nmi_sr_latch.sv
module nmi_sr_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;

  // set dominates a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= 1'b0;
    else         q_q <= set_i | (q_q & ~clr_i);
  end

  assign q_o = q_q;
endmodule

// File: rtl/nmi_trig_latch.sv
module nmi_trig_latch
  import nmi_latch_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pad_i,
  input  logic              mode_wr_i,
  input  logic [DATA_W-1:0] mode_wdata_i,
  input  logic              clr_wr_i,
  input  logic [DATA_W-1:0] clr_data_i,
  input  logic              en_i,
  output logic [1:0]        mode_o,
  output logic              irq_o,
  output logic              pend_o
);
  localparam int unsigned PEND_BIT = 0;
  localparam logic        PAD_IDLE = 1'b1; // idle-high keeps default level-low quiet

  sense_e mode;
  logic   pad_s, evt, clr, latch_q;
  logic   unused_clr;

  assign unused_clr = ^clr_data_i[DATA_W-1:PEND_BIT+1];

  nmi_mode_reg #(.DATA_W(DATA_W)) u_mode (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(mode_wr_i),
    .wdata_i(mode_wdata_i), .mode_o(mode)
  );

  nmi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(PAD_IDLE)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pad_i), .q_o(pad_s)
  );

  nmi_sense #(.RST_VAL(PAD_IDLE)) u_sense (
    .clk_i(clk_i), .rst_ni(rst_ni), .s_i(pad_s), .mode_i(mode), .evt_o(evt)
  );

  assign clr = clr_wr_i & clr_data_i[PEND_BIT];

  nmi_sr_latch u_latch (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(evt), .clr_i(clr), .q_o(latch_q)
  );

  assign mode_o = mode;
  assign irq_o  = latch_q;
  assign pend_o = latch_q & en_i;
endmodule

// File: rtl/nmi_trig_latch_chk.sv
module nmi_trig_latch_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pad_i,
  input logic              mode_wr_i,
  input logic [DATA_W-1:0] mode_wdata_i,
  input logic              clr_wr_i,
  input logic [DATA_W-1:0] clr_data_i,
  input logic              en_i,
  input logic [1:0]        mode_o,
  input logic              irq_o,
  input logic              pend_o
);
  p_pend_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o == (irq_o & en_i));

  p_mode_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr_i |=> mode_o == $past(mode_wdata_i[1:0]));

  p_mode_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_wr_i |=> $stable(mode_o));

  p_fall_only_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(clr_wr_i && clr_data_i[0]));

  p_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !(clr_wr_i && clr_data_i[0])) |=> irq_o);

  p_level_hi_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd2 && $past(mode_o) == 2'd2 && $past(mode_o, 2) == 2'd2 &&
     pad_i && $past(pad_i) && $past(pad_i, 2)) |=> irq_o);
endmodule

bind nmi_trig_latch nmi_trig_latch_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/nmi_trig_latch_test.sv
module nmi_trig_latch_test;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pad = 1'b1;
  logic          mode_wr = 1'b0;
  logic [DW-1:0] mode_wdata = '0;
  logic          clr_wr = 1'b0;
  logic [DW-1:0] clr_data = '0;
  logic          en = 1'b0;
  logic [1:0]    mode;
  logic          irq, pend;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  nmi_trig_latch #(.DATA_W(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .pad_i(pad),
    .mode_wr_i(mode_wr), .mode_wdata_i(mode_wdata),
    .clr_wr_i(clr_wr), .clr_data_i(clr_data), .en_i(en),
    .mode_o(mode), .irq_o(irq), .pend_o(pend)
  );

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_mode(logic [DW-1:0] d);
    mode_wr = 1'b1; mode_wdata = d;
    cyc(1);
    mode_wr = 1'b0; mode_wdata = '0;
  endtask

  task automatic wr_clr(logic [DW-1:0] d);
    clr_wr = 1'b1; clr_data = d;
    cyc(1);
    clr_wr = 1'b0; clr_data = '0;
  endtask

  task automatic chk_pend(string req);
    for (int e = 0; e < 2; e++) begin
      en = e[0];
      #1;
      chk(req, {31'd0, pend}, {31'd0, irq & e[0]});
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #3;
    chk("R1 in reset irq", {31'd0, irq}, 0);
    chk("R1 in reset mode", {30'd0, mode}, 0);
    cyc(2);
    rst_n = 1'b1;
    cyc(4);
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 pend", {31'd0, pend}, 0);
    chk("R1 mode", {30'd0, mode}, 0);

    // R2: only the low two bits load
    for (int v = 0; v < 4; v++) begin
      wr_mode({30'h3FFF_FFFC >> 0, 2'b00} | DW'(v) | 32'hFFFF_FFF0);
      chk("R2 mode load", {30'd0, mode}, v);
      cyc(2);
      chk("R2 mode hold", {30'd0, mode}, v);
    end

    // sweep every mode: idle, activate, clear while active, release, clear
    for (int m = 0; m < 4; m++) begin
      logic idle;
      bit   lvl;
      string rq;
      idle = (m == 0 || m == 1);
      lvl  = (m == 0 || m == 2);
      rq   = (m == 0) ? "R4" : (m == 1) ? "R6" : (m == 2) ? "R3" : "R5";
      pad = idle;
      cyc(4);
      wr_mode(DW'(m));
      wr_clr(32'h1);
      cyc(2);
      chk({rq, " idle"}, {31'd0, irq}, 0);
      pad = ~idle;
      cyc(2);
      chk({rq, " latency edge2"}, {31'd0, irq}, 0);
      cyc(1);
      chk({rq, " set edge3"}, {31'd0, irq}, 1);
      chk_pend("R9 pend set");
      cyc(3);
      chk(lvl ? {rq, " level held"} : {rq, " steady no retrigger"}, {31'd0, irq}, 1);
      wr_clr(32'h1);
      cyc(1);
      chk(lvl ? "R8 set beats clear" : "R7 clear edge mode", {31'd0, irq}, lvl ? 1 : 0);
      pad = idle;
      cyc(4);
      chk(lvl ? "R11 sticky after release" : {rq, " opposite edge ignored"},
          {31'd0, irq}, lvl ? 1 : 0);
      wr_clr(32'hFFFF_FFFE);
      cyc(1);
      chk("R7 bit0 zero ignored", {31'd0, irq}, lvl ? 1 : 0);
      wr_clr(32'h1);
      chk("R7 clear", {31'd0, irq}, 0);
      chk_pend("R9 pend clear");
    end

    // R10: mode change keeps a set latch and makes no edge
    pad = 1'b0;
    cyc(4);
    wr_mode(DW'(3));
    wr_clr(32'h1);
    pad = 1'b1;
    cyc(4);
    chk("R5 rise sets", {31'd0, irq}, 1);
    wr_mode(DW'(1));
    cyc(3);
    chk("R10 mode change keeps latch", {31'd0, irq}, 1);
    wr_clr(32'h1);
    cyc(3);
    chk("R10 steady pad no event after switch", {31'd0, irq}, 0);
    wr_mode(DW'(3));
    cyc(3);
    chk("R10 switch back no event", {31'd0, irq}, 0);
    wr_mode(DW'(0));
    cyc(3);
    chk("R10 level-low with high pad stays clear", {31'd0, irq}, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule